// File: doc/BRIEF.md
# Microwire Master/Slave Serial Shift Port

This block is an eight-bit serial shift port for Microwire-style three-wire links. Software writes a byte into the shift register and raises the BUSY flag to start a transfer. The byte then leaves most significant bit first on the serial output. At the same time, the bits arriving on the serial input are collected into the same register. When all eight bits have moved, the register holds the received byte. BUSY drops by itself at that point, and an optional one-cycle completion pulse acts as the interrupt.

The port works in one of two modes. As a master, it produces the shift clock from the system clock, and a two-bit select sets the clock period to 2, 4 or 8 system cycles. As a slave, it follows an externally supplied shift clock, which it passes through a synchroniser before looking for edges. Software can clear BUSY part way through a transfer to stop after fewer than eight bits. Two per-pin configuration bits, qualified by a port enable, decide whether the serial output is driven or left floating and whether the clock pin drives or listens.

The byte load is the only data path into the block. It uses a valid/ready handshake. `load_ready` is high exactly when no transfer is running. A load offered while a transfer runs is simply not taken, and the load is not held for later, so the driver must hold `load_valid` until ready returns. The received byte is always visible on `shift_data`. All control pins are plain levels or single-cycle pulses.

Top module: `mw_shift_port`

## Requirements
- R1: After reset, `busy`, `sk_out` and `done_irq` are 0, `shift_data` is 0x00 and `load_ready` is 1.
- R2: `load_ready` equals NOT `busy`. A byte taken with `load_valid` and `load_ready` both high appears on `shift_data` one cycle later. A byte offered while `busy` is high is not taken and does not change the result of the transfer.
- R3: A `busy_set` pulse while `port_en` is 1 and no transfer runs raises `busy` on the next cycle. With `port_en` at 0, `busy_set` leaves `busy` at 0.
- R4: In master mode (`sk_int_cfg` = 1), `clk_sel` sets the shift clock period P: 00 gives 2 cycles, 01 gives 4, and 10 or 11 give 8. The clock is low for P/2 and then high for P/2. `sk_out` is low whenever no transfer runs. `busy` falls 8·P cycles after the edge that raised it.
- R5: Data moves most significant bit first. `so_out` shows bit 7 of the shift register and changes only on falling shift-clock edges. The serial input is sampled on rising edges. After a full transfer, `shift_data` holds the eight received bits and the peer has received the loaded byte.
- R6: On the eighth falling edge, `busy` clears without help from software. In the same cycle that `busy` goes low, `done_irq` is high for exactly one cycle if `irq_en` is 1. `done_irq` stays low if `irq_en` is 0.
- R7: A `busy_clr` pulse during a transfer stops it at once. `busy` is 0 and `sk_out` is 0 on the next cycle, and no `done_irq` is produced. `shift_data` keeps the bits shifted so far: after k falling edges, the loaded byte shifted left by k with the k received bits in the low end.
- R8: In slave mode (`sk_int_cfg` = 0), `sk_in` and the serial input pass through a two-flop synchroniser. The port shifts on the detected edges of the external clock and finishes after eight falling edges, with the same data behaviour as R5 and R6.
- R9: `so_oe` is 1 only when `port_en` and `so_drive_cfg` are both 1. `sk_oe` is 1 only when `port_en` and `sk_int_cfg` are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System (instruction-cycle) clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| port_en | input | 1 | Enables the serial pins and transfer starts |
| sk_int_cfg | input | 1 | Clock pin: 1 = internal clock (master), 0 = external clock (slave) |
| so_drive_cfg | input | 1 | Output pin: 1 = drive, 0 = tri-state |
| clk_sel | input | 2 | Master clock period select |
| irq_en | input | 1 | Enables the completion pulse |
| load_valid | input | 1 | Offers a byte for the shift register |
| load_data | input | DATA_W | Byte to load |
| load_ready | output | 1 | High when a load can be taken |
| busy_set | input | 1 | Pulse: start a transfer |
| busy_clr | input | 1 | Pulse: stop the transfer now |
| busy | output | 1 | Transfer in progress |
| shift_data | output | DATA_W | Shift register contents |
| done_irq | output | 1 | One-cycle completion pulse |
| sk_in | input | 1 | External shift clock (slave) |
| si_in | input | 1 | Serial data input |
| sk_out | output | 1 | Generated shift clock (master) |
| sk_oe | output | 1 | Output enable for the clock pin |
| so_out | output | 1 | Serial data output |
| so_oe | output | 1 | Output enable for the data pin |

## Verification
A load shows on `shift_data` one cycle after the edge that takes it. `busy` rises one cycle after `busy_set`. In master mode, `busy` falls exactly 8·P cycles after that edge, and `done_irq` is sampled in the same cycle. An abort takes effect on the edge that samples `busy_clr`, so `busy` and `sk_out` are checked low one cycle later. The bench drives every input and samples every output on the falling system-clock edge. The scoreboard timestamps the first cycle `busy` is seen high and compares the elapsed count, the received byte and the completion pulse when `busy` is first seen low. In slave mode, the synchroniser adds about three cycles of latency. The bench covers this by keeping each external clock phase four cycles long and checking only the data and the pulse, not the cycle count.

// File: rtl/mw_pkg.sv
package mw_pkg;

  // master clock period select codes
  typedef enum logic [1:0] {
    SKSEL_P2  = 2'b00,
    SKSEL_P4  = 2'b01,
    SKSEL_P8  = 2'b10,
    SKSEL_P8B = 2'b11
  } sk_sel_e;

  // half period of the master shift clock, in system cycles
  function automatic logic [3:0] half_period(input logic [1:0] sel);
    case (sel)
      SKSEL_P2: half_period = 4'd1;
      SKSEL_P4: half_period = 4'd2;
      default:  half_period = 4'd4;
    endcase
  endfunction

endpackage

// File: rtl/mw_clkdiv.sv
module mw_clkdiv #(
  parameter int CNT_W = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [1:0] clk_sel,
  output logic       sk,
  output logic       rise_stb,
  output logic       fall_stb
);
  logic [3:0]       half;
  logic [CNT_W-1:0] lim;
  logic [CNT_W-1:0] cnt;
  logic             tick;

  assign half     = mw_pkg::half_period(clk_sel);
  assign lim      = CNT_W'(half - 4'd1);
  assign tick     = run && (cnt == lim);
  assign rise_stb = tick && !sk;
  assign fall_stb = tick && sk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      sk  <= 1'b0;
    end else if (!run) begin
      cnt <= '0;
      sk  <= 1'b0;
    end else if (tick) begin
      cnt <= '0;
      sk  <= ~sk;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/mw_sync.sv
module mw_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= din;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/mw_shifter.sv
module mw_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [DATA_W-1:0] load_data,
  input  logic              start,
  input  logic              rise,
  input  logic              fall,
  input  logic              si,
  output logic [DATA_W-1:0] data,
  output logic              msb,
  output logic              last_fall
);
  localparam int BC_W = $clog2(DATA_W);

  logic [BC_W-1:0] bitcnt;
  logic            cap;

  assign msb       = data[DATA_W-1];
  assign last_fall = fall && (bitcnt == BC_W'(DATA_W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data   <= '0;
      cap    <= 1'b0;
      bitcnt <= '0;
    end else begin
      if (load_en)   data <= load_data;
      else if (fall) data <= {data[DATA_W-2:0], cap};
      if (rise)      cap  <= si;
      if (start)     bitcnt <= '0;
      else if (fall) bitcnt <= bitcnt + 1'b1;
    end
  end
endmodule

// File: rtl/mw_shift_port.sv
module mw_shift_port #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int DIV_W       = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              port_en,
  input  logic              sk_int_cfg,
  input  logic              so_drive_cfg,
  input  logic [1:0]        clk_sel,
  input  logic              irq_en,
  input  logic              load_valid,
  input  logic [DATA_W-1:0] load_data,
  output logic              load_ready,
  input  logic              busy_set,
  input  logic              busy_clr,
  output logic              busy,
  output logic [DATA_W-1:0] shift_data,
  output logic              done_irq,
  input  logic              sk_in,
  input  logic              si_in,
  output logic              sk_out,
  output logic              sk_oe,
  output logic              so_out,
  output logic              so_oe
);
  logic       run, start, load_fire, master;
  logic       m_sk, m_rise, m_fall;
  logic [1:0] sync_q;
  logic       sk_s, si_s, sk_prev;
  logic       s_rise, s_fall;
  logic       rise, fall, si_sel, last_fall;

  assign master     = sk_int_cfg;
  assign load_ready = !busy;
  assign load_fire  = load_valid && load_ready;
  assign start      = busy_set && port_en && !busy && !busy_clr;
  assign run        = busy && !busy_clr;

  mw_clkdiv #(.CNT_W(DIV_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run && master),
    .clk_sel  (clk_sel),
    .sk       (m_sk),
    .rise_stb (m_rise),
    .fall_stb (m_fall)
  );

  mw_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   ({sk_in, si_in}),
    .dout  (sync_q)
  );

  assign sk_s = sync_q[1];
  assign si_s = sync_q[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sk_prev <= 1'b0;
    else        sk_prev <= sk_s;
  end

  assign s_rise = run && !master && sk_s && !sk_prev;
  assign s_fall = run && !master && !sk_s && sk_prev;

  assign rise   = master ? m_rise : s_rise;
  assign fall   = master ? m_fall : s_fall;
  assign si_sel = master ? si_in  : si_s;

  mw_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_en   (load_fire),
    .load_data (load_data),
    .start     (start),
    .rise      (rise),
    .fall      (fall),
    .si        (si_sel),
    .data      (shift_data),
    .msb       (so_out),
    .last_fall (last_fall)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      done_irq <= 1'b0;
    end else begin
      if (start)          busy <= 1'b1;
      else if (busy_clr)  busy <= 1'b0;
      else if (last_fall) busy <= 1'b0;
      done_irq <= last_fall && irq_en;
    end
  end

  assign sk_out = m_sk;
  assign sk_oe  = port_en && sk_int_cfg;
  assign so_oe  = port_en && so_drive_cfg;
endmodule

module mw_shift_port_chk (
  input logic clk,
  input logic rst_n,
  input logic port_en,
  input logic irq_en,
  input logic busy,
  input logic busy_clr,
  input logic sk_out,
  input logic done_irq
);
  // R4
  sk_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sk_out);
  // R4
  sk_rise_in_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sk_out) |-> busy);
  // R6
  done_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |-> (!busy && $past(busy)));
  // R6
  done_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |=> !done_irq);
  // R6
  done_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |-> $past(irq_en));
  // R7
  abort_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && busy_clr) |=> (!busy && !done_irq));
  // R3
  no_start_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!port_en && !busy) |=> !busy);
endmodule

bind mw_shift_port mw_shift_port_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .port_en  (port_en),
  .irq_en   (irq_en),
  .busy     (busy),
  .busy_clr (busy_clr),
  .sk_out   (sk_out),
  .done_irq (done_irq)
);

// File: tb/mw_shift_port_test.sv
module mw_shift_port_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       port_en = 1'b0, sk_int_cfg = 1'b0, so_drive_cfg = 1'b0, irq_en = 1'b0;
  logic [1:0] clk_sel = 2'b00;
  logic       load_valid = 1'b0;
  logic [7:0] load_data = 8'h00;
  logic       load_ready, busy, done_irq;
  logic       busy_set = 1'b0, busy_clr = 1'b0;
  logic [7:0] shift_data;
  logic       sk_in = 1'b0, si_in, si_drv = 1'b0, slave_mode = 1'b0;
  logic       sk_out, sk_oe, so_out, so_oe;
  logic [7:0] peer_tx = 8'h00, peer_rx = 8'h00;

  int checks = 0, fails = 0;
  int cyc = 0, start_cyc = 0;
  logic busy_q = 1'b0;

  typedef struct {
    logic [7:0] data;
    logic       done;
    int         cycles;
  } exp_t;
  exp_t sb[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign si_in = slave_mode ? si_drv : peer_tx[7];

  // peer device on the far side of the link in master mode
  always @(posedge sk_out) peer_rx <= {peer_rx[6:0], so_out};
  always @(negedge sk_out) peer_tx <= {peer_tx[6:0], 1'b0};

  mw_shift_port uut (
    .clk(clk), .rst_n(rst_n), .port_en(port_en), .sk_int_cfg(sk_int_cfg),
    .so_drive_cfg(so_drive_cfg), .clk_sel(clk_sel), .irq_en(irq_en),
    .load_valid(load_valid), .load_data(load_data), .load_ready(load_ready),
    .busy_set(busy_set), .busy_clr(busy_clr), .busy(busy),
    .shift_data(shift_data), .done_irq(done_irq), .sk_in(sk_in), .si_in(si_in),
    .sk_out(sk_out), .sk_oe(sk_oe), .so_out(so_out), .so_oe(so_oe)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor: compares every end of transfer
  always @(negedge clk) begin
    if (rst_n) begin
      if (!busy_q && busy) start_cyc = cyc;
      if (busy_q && !busy) begin
        if (sb.size() == 0) begin
          check(1'b0, "R6 unexpected end of transfer", 32'(shift_data), 32'h0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(shift_data == e.data, "R5/R7 shift_data at end", 32'(shift_data), 32'(e.data));
          check(done_irq == e.done, "R6/R7 done_irq at end", 32'(done_irq), 32'(e.done));
          if (e.cycles > 0)
            check((cyc - start_cyc) == e.cycles, "R4 transfer length",
                  32'(cyc - start_cyc), 32'(e.cycles));
        end
      end
      busy_q = busy;
    end
  end

  task automatic load_byte(input logic [7:0] d);
    @(negedge clk);
    load_valid = 1'b1;
    load_data  = d;
    @(negedge clk);
    load_valid = 1'b0;
    check(shift_data == d, "R2 load appears next cycle", 32'(shift_data), 32'(d));
  endtask

  task automatic pulse_set();
    @(negedge clk);
    busy_set = 1'b1;
    @(negedge clk);
    busy_set = 1'b0;
  endtask

  task automatic master_xfer(input logic [1:0] sel, input logic [7:0] tx,
                             input logic [7:0] rx, input logic irq, input bit mid_load);
    exp_t e;
    int p;
    p = (sel == 2'b00) ? 2 : (sel == 2'b01) ? 4 : 8;
    slave_mode = 1'b0; sk_int_cfg = 1'b1; clk_sel = sel; irq_en = irq;
    load_byte(tx);
    peer_tx = rx; peer_rx = 8'h00;
    e.data = rx; e.done = irq; e.cycles = 8 * p;
    sb.push_back(e);
    pulse_set();
    check(busy == 1'b1, "R3 busy after set", 32'(busy), 32'h1);
    if (mid_load) begin
      load_valid = 1'b1; load_data = 8'hFF;
      check(load_ready == 1'b0, "R2 load_ready low while busy", 32'(load_ready), 32'h0);
      @(negedge clk);
      load_valid = 1'b0;
    end
    while (busy) @(negedge clk);
    check(peer_rx == tx, "R5 peer received byte MSB first", 32'(peer_rx), 32'(tx));
    check(sk_out == 1'b0, "R4 clock idle low", 32'(sk_out), 32'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check(busy == 1'b0, "R1 busy reset", 32'(busy), 32'h0);
    check(sk_out == 1'b0, "R1 sk_out reset", 32'(sk_out), 32'h0);
    check(done_irq == 1'b0, "R1 done reset", 32'(done_irq), 32'h0);
    check(shift_data == 8'h00, "R1 shift_data reset", 32'(shift_data), 32'h0);
    check(load_ready == 1'b1, "R1 load_ready reset", 32'(load_ready), 32'h1);

    // R9 output enables for every configuration
    for (int k = 0; k < 8; k++) begin
      port_en = k[2]; so_drive_cfg = k[1]; sk_int_cfg = k[0];
      #1;
      check(so_oe == (k[2] & k[1]), "R9 so_oe", 32'(so_oe), 32'(k[2] & k[1]));
      check(sk_oe == (k[2] & k[0]), "R9 sk_oe", 32'(sk_oe), 32'(k[2] & k[0]));
    end

    // R3 start ignored while port disabled
    port_en = 1'b0; sk_int_cfg = 1'b1; so_drive_cfg = 1'b1;
    pulse_set();
    @(negedge clk);
    check(busy == 1'b0, "R3 busy_set ignored when disabled", 32'(busy), 32'h0);
    port_en = 1'b1;

    // R4 R5 R6 master transfers, all clock selects
    master_xfer(2'b00, 8'hA5, 8'h3C, 1'b1, 1'b0);
    master_xfer(2'b01, 8'h81, 8'h7E, 1'b1, 1'b0);
    master_xfer(2'b10, 8'h5A, 8'hC3, 1'b1, 1'b1);   // R2 load during busy
    master_xfer(2'b11, 8'h0F, 8'hF0, 1'b0, 1'b0);   // R6 no pulse when disabled

    // R7 abort after three falling edges
    begin
      exp_t e;
      clk_sel = 2'b00; irq_en = 1'b1; slave_mode = 1'b0;
      load_byte(8'hA5);
      peer_tx = 8'h3C;
      e.data = 8'h29; e.done = 1'b0; e.cycles = 0;
      sb.push_back(e);
      pulse_set();
      repeat (3) @(negedge sk_out);
      @(negedge clk);
      busy_clr = 1'b1;
      @(negedge clk);
      busy_clr = 1'b0;
      check(busy == 1'b0, "R7 busy low after abort", 32'(busy), 32'h0);
      check(sk_out == 1'b0, "R7 sk_out low after abort", 32'(sk_out), 32'h0);
      repeat (4) @(negedge clk);
      check(shift_data == 8'h29, "R7 partial data held", 32'(shift_data), 32'h29);
    end

    // R8 slave transfer on an external clock
    begin
      exp_t e;
      logic [7:0] tx, rx, cap;
      tx = 8'hB4; rx = 8'h6D; cap = 8'h00;
      slave_mode = 1'b1; sk_int_cfg = 1'b0; irq_en = 1'b1;
      load_byte(tx);
      e.data = rx; e.done = 1'b1; e.cycles = 0;
      sb.push_back(e);
      si_drv = rx[7];
      pulse_set();
      for (int i = 0; i < 8; i++) begin
        repeat (4) @(negedge clk);
        sk_in = 1'b1;
        cap = {cap[6:0], so_out};
        repeat (4) @(negedge clk);
        sk_in = 1'b0;
        if (i < 7) si_drv = rx[6-i];
      end
      repeat (6) @(negedge clk);
      check(busy == 1'b0, "R8 slave busy auto clear", 32'(busy), 32'h0);
      check(cap == tx, "R8 slave so_out MSB first", 32'(cap), 32'(tx));
      check(sk_out == 1'b0, "R8 sk_out idle in slave mode", 32'(sk_out), 32'h0);
    end

    repeat (4) @(negedge clk);
    check(sb.size() == 0, "R6 all transfers ended", 32'(sb.size()), 32'h0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule